// File: doc/BRIEF.md
# Pipelined Largest and Runner-Up Finder

This block takes a wide vector of unsigned lanes on every clock and reports the largest lane value and the second-largest lane value. It works in two passes. A first registered comparison tree reduces the lanes to a single winner and keeps track of which lane won. A copy of the input vector is delayed until that lane number is known. The winning lane in the copy is then cleared to zero, and a second registered tree reduces the cleared copy to find the runner-up.

Only one lane is cleared. A maximum value that occurs in two or more lanes therefore also shows up as the runner-up. If several lanes hold the maximum, the lowest-numbered of them is treated as the winner. The block is fully pipelined: a new vector may enter on every cycle. Each result leaves with a valid flag, and the largest value is delayed so that it appears on the same cycle as its runner-up.

Top module: `top2_finder`

## Requirements
- R1: A new vector may be presented with `in_valid` high on every clock, including back-to-back cycles, and each vector gets its own result.
- R2: `out_max` equals the largest lane value of its vector, where lanes are compared as unsigned numbers.
- R3: `out_second` equals the largest value that remains after exactly one lane holding the maximum is set to zero. It is zero when every other lane is zero.
- R4: Both results for a vector sampled at clock edge k become visible just after edge k+10, which is eleven register stages, or 2*log2(lanes)+1.
- R5: `out_valid` is high in exactly the output cycles that belong to vectors sampled with `in_valid` high. A gap at the input gives a gap at the output.
- R6: While `rst` is high, and after it is released until the first valid vector has passed through, `out_valid` is low. Only the valid pipeline is reset.
- R7: Whenever `out_valid` is high, `out_second` is not greater than `out_max`.
- R8: Lane i is located at `in_data[i*DATA_W +: DATA_W]`. The extreme values zero and all-ones are handled in both the first lane and the last lane.
- R9: If the maximum appears in two or more lanes, including the case where all lanes are equal, `out_second` equals `out_max`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Marks `in_data` as a vector to process |
| in_data | input | N_LANES*DATA_W | Packed unsigned lanes, lane 0 in the low bits |
| out_valid | output | 1 | Results on this cycle belong to a valid vector |
| out_max | output | DATA_W | Largest lane value |
| out_second | output | DATA_W | Runner-up after one winning lane is removed |

## Verification
The bench builds the block with its default parameters: 32 lanes of 8 bits. The narrow width makes it cheap to drive the all-ones value into any lane. Random vectors also repeat values often, so the bench reaches ties for the maximum, which exercise the lowest-lane choice and the case where the runner-up equals the maximum, without needing special patterns. With 32 lanes the trees are five levels deep, so the full eleven-stage alignment between the two results is checked against a behavioural queue model.

// File: rtl/tt_pkg.sv
package tt_pkg;
  // Number of pairwise reduction levels for a power-of-two lane count.
  function automatic int tt_levels(input int n);
    return $clog2(n);
  endfunction
endpackage

// File: rtl/tt_max_tree.sv
// Registered pairwise maximum tree, heap layout: node k has children 2k, 2k+1.
// Leaves are the inputs at positions N_IN..2*N_IN-1; node 1 is the root.
module tt_max_tree #(
  parameter int N_IN  = 32,
  parameter int KEY_W = 8
) (
  input  logic                   clk,
  input  logic [N_IN*KEY_W-1:0]  keys_i,
  output logic [KEY_W-1:0]       max_o
);
  logic [KEY_W-1:0] node [1:N_IN-1];
  logic [KEY_W-1:0] ch   [2:2*N_IN-1];

  always_comb begin
    for (int k = 2; k < N_IN; k++) ch[k] = node[k];
    for (int k = 0; k < N_IN; k++) ch[N_IN+k] = keys_i[k*KEY_W +: KEY_W];
  end

  // Left child covers the lower lanes and wins on a tie.
  always_ff @(posedge clk) begin
    for (int k = 1; k < N_IN; k++)
      node[k] <= (ch[2*k+1] > ch[2*k]) ? ch[2*k+1] : ch[2*k];
  end

  assign max_o = node[1];
endmodule

// File: rtl/tt_delay_line.sv
// Plain register delay of DEPTH stages, no reset.
module tt_delay_line #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 5
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe [DEPTH];

  always_ff @(posedge clk) begin
    pipe[0] <= d_i;
    for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
  end

  assign q_o = pipe[DEPTH-1];
endmodule

// File: rtl/tt_lane_mask.sv
// Registered clear of one selected lane.
module tt_lane_mask #(
  parameter int N_LANES = 32,
  parameter int DATA_W  = 8,
  localparam int IDX_W  = $clog2(N_LANES)
) (
  input  logic                      clk,
  input  logic [N_LANES*DATA_W-1:0] vec_i,
  input  logic [IDX_W-1:0]          idx_i,
  output logic [N_LANES*DATA_W-1:0] vec_o
);
  always_ff @(posedge clk) begin
    for (int l = 0; l < N_LANES; l++)
      vec_o[l*DATA_W +: DATA_W] <= (idx_i == IDX_W'(l)) ? '0 : vec_i[l*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/top2_finder.sv
module top2_finder
  import tt_pkg::*;
#(
  parameter int N_LANES = 32,
  parameter int DATA_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [N_LANES*DATA_W-1:0] in_data,
  output logic                      out_valid,
  output logic [DATA_W-1:0]         out_max,
  output logic [DATA_W-1:0]         out_second
);
  localparam int LEVELS  = tt_levels(N_LANES);
  localparam int IDX_W   = LEVELS;
  localparam int KEY1_W  = DATA_W + IDX_W;
  localparam int LATENCY = 2 * LEVELS + 1;

  // Pass 1 keys: value above inverted lane number, so a lower lane wins ties.
  logic [N_LANES*KEY1_W-1:0] keys1;
  for (genvar l = 0; l < N_LANES; l++) begin : g_key
    assign keys1[l*KEY1_W +: KEY1_W] = {in_data[l*DATA_W +: DATA_W], ~IDX_W'(l)};
  end

  logic [KEY1_W-1:0] win_key;
  tt_max_tree #(.N_IN(N_LANES), .KEY_W(KEY1_W)) u_tree1 (
    .clk(clk), .keys_i(keys1), .max_o(win_key)
  );

  logic [DATA_W-1:0] win_val;
  logic [IDX_W-1:0]  win_idx;
  assign win_val = win_key[KEY1_W-1:IDX_W];
  assign win_idx = ~win_key[IDX_W-1:0];

  // Raw copy aligned with the winner leaving pass 1.
  logic [N_LANES*DATA_W-1:0] data_dly;
  tt_delay_line #(.WIDTH(N_LANES*DATA_W), .DEPTH(LEVELS)) u_data_dly (
    .clk(clk), .d_i(in_data), .q_o(data_dly)
  );

  logic [N_LANES*DATA_W-1:0] masked;
  tt_lane_mask #(.N_LANES(N_LANES), .DATA_W(DATA_W)) u_mask (
    .clk(clk), .vec_i(data_dly), .idx_i(win_idx), .vec_o(masked)
  );

  // Pass 2 on the cleared copy; its root register drives out_second.
  tt_max_tree #(.N_IN(N_LANES), .KEY_W(DATA_W)) u_tree2 (
    .clk(clk), .keys_i(masked), .max_o(out_second)
  );

  // Hold the maximum for the mask stage plus pass 2.
  tt_delay_line #(.WIDTH(DATA_W), .DEPTH(LEVELS + 1)) u_max_dly (
    .clk(clk), .d_i(win_val), .q_o(out_max)
  );

  logic [LATENCY-1:0] vld_pipe;
  always_ff @(posedge clk) begin
    if (rst) vld_pipe <= '0;
    else     vld_pipe <= {vld_pipe[LATENCY-2:0], in_valid};
  end
  assign out_valid = vld_pipe[LATENCY-1];
endmodule

// File: rtl/top2_finder_chk.sv
module top2_finder_chk #(
  parameter int N_LANES = 32,
  parameter int DATA_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_max,
  input logic [DATA_W-1:0] out_second
);
  localparam int LATENCY = 2 * $clog2(N_LANES) + 1;

  // Vectors accepted but not yet reported.
  int pend;
  always_ff @(posedge clk) begin
    if (rst) pend <= 0;
    else     pend <= pend + int'(in_valid) - int'(out_valid);
  end

  // R7
  a_r7_second_not_above: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_second <= out_max));

  // R5: no result without an accepted vector
  a_r5_no_orphan_valid: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (pend > 0));

  // R4: no more vectors in flight than pipeline stages
  a_r4_inflight_bound: assert property (@(posedge clk) disable iff (rst)
    pend <= LATENCY);

  // R6
  a_r6_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !out_valid);
endmodule

bind top2_finder top2_finder_chk #(.N_LANES(N_LANES), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .out_max(out_max), .out_second(out_second)
);

// File: tb/tb_top2_finder.sv
`timescale 1ns/1ps
module tb_top2_finder;
  localparam int N   = 32;
  localparam int DW  = 8;
  localparam int LAT = 11;
  localparam int WATCH = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [N*DW-1:0] in_data = '0;
  logic out_valid;
  logic [DW-1:0] out_max, out_second;

  always #4 clk = ~clk;

  top2_finder #(.N_LANES(N), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_max(out_max), .out_second(out_second)
  );

  typedef struct { bit v; int mx; int sc; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_bad = 0, cyc = 0;
  int lane [N];
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic exp_t model(input bit v);
    exp_t e; int top, pos;
    top = -1; pos = 0;
    for (int i = 0; i < N; i++) if (lane[i] > top) begin top = lane[i]; pos = i; end
    e.v = v; e.mx = top; e.sc = 0;
    for (int i = 0; i < N; i++) if (i != pos && lane[i] > e.sc) e.sc = lane[i];
    return e;
  endfunction

  task automatic report;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // One cycle: compare the entry now due (R4 alignment), then drive the next.
  task automatic step(input bit v);
    exp_t e;
    @(negedge clk);
    if (q.size() == LAT) begin
      e = q.pop_front();
      n_chk++;
      if (out_valid !== e.v) begin
        n_bad++; $display("FAIL R5 valid: got %0b exp %0b", out_valid, e.v);
      end else if (e.v && out_max !== DW'(e.mx)) begin
        n_bad++; $display("FAIL R2 max: got %0d exp %0d", out_max, e.mx);
      end else if (e.v && out_second !== DW'(e.sc)) begin
        n_bad++; $display("FAIL R3 second: got %0d exp %0d", out_second, e.sc);
      end
    end else begin
      n_chk++; // R6: pipeline still draining zeros from reset
      if (out_valid !== 1'b0) begin
        n_bad++; $display("FAIL R6 valid before fill: got %0b exp 0", out_valid);
      end
    end
    for (int i = 0; i < N; i++) in_data[i*DW +: DW] = DW'(lane[i]);
    in_valid = v;
    q.push_back(model(v));
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    q.delete();
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic fill(input int val);
    for (int i = 0; i < N; i++) lane[i] = val;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R6: right after reset release
    n_chk++;
    if (out_valid !== 1'b0) begin n_bad++; $display("FAIL R6 reset: got %0b exp 0", out_valid); end
    // R8: zeros, all-ones, extremes at lane 0 and lane 31
    fill(0); step(1);
    fill(255); step(1);                          // R9 all equal
    fill(0); lane[0] = 255; step(1);
    fill(0); lane[31] = 255; step(1);
    fill(7); lane[31] = 255; lane[0] = 254; step(1);
    fill(1); lane[3] = 200; lane[17] = 200; step(1); // R9 duplicate maximum
    for (int i = 0; i < N; i++) lane[i] = i; step(1);
    for (int i = 0; i < N; i++) lane[i] = 255 - i; step(1);
    // R1 back-to-back random, R5 gaps interleaved
    for (int t = 0; t < 2000; t++) begin
      for (int i = 0; i < N; i++) lane[i] = (t % 3 == 0) ? int'($urandom_range(0, 15)) : int'($urandom_range(0, 255));
      step((t % 7 == 3) ? 1'b0 : 1'b1);
    end
    // R6: reset in mid-stream, then resume
    do_reset();
    for (int t = 0; t < 200; t++) begin
      for (int i = 0; i < N; i++) lane[i] = int'($urandom_range(0, 255));
      step(t[0]);
    end
    fill(0); for (int t = 0; t < LAT + 1; t++) step(0);
    done = 1;
    report();
  end

  initial begin
    repeat (WATCH) @(posedge clk);
    if (!done) begin
      n_bad++; $display("FAIL watchdog: got %0d cycles exp fewer", cyc);
      report();
    end
  end
endmodule